// File: doc/BRIEF.md
# Toeplitz Receive-Side-Scaling Queue Selector

This block sits in a 512-bit packet stream and picks a receive queue for every packet. With each packet comes a 96-bit flow tuple: source IPv4 address, destination IPv4 address, source port and destination port. The block computes a Toeplitz hash of that tuple against a key that software programs. The low bits of the hash index a 64-entry indirection table, and the queue number found there is written into the packet's metadata. The tuple and the metadata are only meaningful on the final beat of a packet. The queue therefore lands on that same beat, and the stream data is passed through unchanged.

The pipeline has a fixed depth of two registers and accepts one beat every clock cycle. The only thing that stalls it is a low downstream ready. A single write port loads the key words, the table entries and the enable bit. When the enable bit is clear, the metadata passes through untouched.

Top module: `rss_queue_select`

## Requirements
- R1: The tuple is `s_tuple[95:0]`: source address in bits 95:64, destination address in 63:32, source port in 31:16 and destination port in 15:0. Tuple bit i is counted from bit 95 (i = 0) downwards. Key bit j is counted from the MSB of key word 0, so key word n covers key bits 16n to 16n+15, MSB first. The 32-bit hash starts at zero, and for every tuple bit i that is set, the 32 key bits i..i+31 are XORed into it, with key bit i landing in hash bit 31.
- R2: An all-zero tuple needs no special case. Its hash is zero, so the packet receives table entry 0.
- R3: When the block is enabled, the last beat of a packet leaves with `m_meta[7:0]` set to table entry `hash[5:0]`. Bits 31:8 of the metadata, and all of the metadata on earlier beats, are unchanged.
- R4: Write map on `cfg_addr` when `cfg_we` is high: 0 to 19 load key word n from `cfg_wdata[15:0]`; 64 to 127 load table entry (addr-64) from `cfg_wdata[7:0]`; 128 loads the enable bit from `cfg_wdata[0]`.
- R5: When the enable bit is clear, `m_meta` equals the input metadata on every beat, the last beat included.
- R6: `s_tready` is high whenever the output holds no beat or `m_tready` is high, so a stream with `m_tready` held high is taken at one beat per cycle.
- R7: While `m_tvalid` is high and `m_tready` is low, all output stream signals and `m_meta` hold their values.
- R8: A beat accepted at clock edge e appears on the outputs after edge e+1 when the output is free. Data, keep and last pass through unchanged and in order.
- R9: A packet takes the key as it stood on the edge that accepted its last beat, so a key write issued after that edge does not change its queue. Writes issued while the block is empty apply to every later packet.
- R10: Reset, synchronous and active high, clears both valid stages, the key, the table and the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration write address |
| cfg_wdata | input | 16 | Configuration write data |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tdata | input | DATA_W | Input packet data |
| s_tkeep | input | DATA_W/8 | Input byte enables |
| s_tlast | input | 1 | Input last beat of packet |
| s_tuple | input | 96 | Flow tuple, valid with s_tlast |
| s_meta | input | META_W | Input metadata, valid with s_tlast |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | DATA_W | Output packet data |
| m_tkeep | output | DATA_W/8 | Output byte enables |
| m_tlast | output | 1 | Output last beat of packet |
| m_meta | output | META_W | Output metadata carrying the queue |

## Verification
The assertions watch the stream contract on every cycle: ready is never withheld while the output is empty, a stalled output does not move, an accepted beat comes out after the fixed delay, writes to a table entry or to the enable bit land as addressed, and a zero tuple folds to index zero. Whether the hash matches the Toeplitz rule for particular keys and tuples, whether disabled packets come out unmodified, and whether an in-flight packet keeps its old key can only be seen from the bench's scenarios, which compare every output beat against a model built from the requirements.

// File: rtl/rss_pkg.sv
package rss_pkg;

    // Tuple and hash geometry
    localparam int TUPLE_W      = 96;
    localparam int TUPLE_WORD_W = 32;
    localparam int TUPLE_WORDS  = TUPLE_W / TUPLE_WORD_W;
    localparam int HASH_W       = 32;

    // Key storage as seen by software
    localparam int KEY_WORD_W   = 16;
    localparam int KEY_WORDS    = 20;

    // Indirection table
    localparam int TBL_DEPTH    = 64;
    localparam int IDX_W        = $clog2(TBL_DEPTH);
    localparam int QUEUE_W      = 8;

    // Only hash bits [IDX_W-1:0] are consumed; they touch key bits KEY_LO..KEY_HI
    localparam int KEY_LO       = HASH_W - IDX_W;
    localparam int KEY_HI       = TUPLE_W + HASH_W - 2;
    localparam int KEPT_W       = KEY_HI - KEY_LO + 1;
    localparam int WORD_SPAN_W  = TUPLE_WORD_W + IDX_W - 1;

    // Configuration write map
    localparam int CFG_ADDR_W   = 8;
    localparam int CFG_DATA_W   = KEY_WORD_W;
    localparam int TBL_BASE     = 64;
    localparam int EN_ADDR      = TBL_BASE + TBL_DEPTH;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_KEY,
        TGT_TBL,
        TGT_EN
    } cfg_tgt_e;

    typedef struct packed {
        logic                  we;
        logic [CFG_ADDR_W-1:0] addr;
        logic [CFG_DATA_W-1:0] data;
    } cfg_wr_t;

    typedef logic [KEPT_W-1:0] kept_key_t;

    function automatic cfg_tgt_e cfg_target(input logic [CFG_ADDR_W-1:0] addr);
        int a;
        a = int'(addr);
        if (a < KEY_WORDS)                             return TGT_KEY;
        if (a >= TBL_BASE && a < TBL_BASE + TBL_DEPTH) return TGT_TBL;
        if (a == EN_ADDR)                              return TGT_EN;
        return TGT_NONE;
    endfunction

    // Contribution of one 32-bit tuple word to the table index.
    // Index bit b gathers tuple bit p against kept key bit p+b.
    function automatic logic [IDX_W-1:0] word_fold(
        input logic [TUPLE_WORD_W-1:0] t,
        input logic [WORD_SPAN_W-1:0]  k
    );
        logic [IDX_W-1:0] r;
        r = '0;
        for (int p = 0; p < TUPLE_WORD_W; p++) begin
            for (int b = 0; b < IDX_W; b++) begin
                r[b] = r[b] ^ (t[p] & k[p+b]);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rss_cfg_regs.sv
module rss_cfg_regs
    import rss_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cfg_wr_t            wr,
    output kept_key_t          key_bits,
    output logic               enable,
    output logic               tbl_we,
    output logic [IDX_W-1:0]   tbl_idx,
    output logic [QUEUE_W-1:0] tbl_data
);

    cfg_tgt_e tgt;
    assign tgt = cfg_target(wr.addr);

    // Kept bit q holds key bit KEY_HI-q; locate its word and data bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            key_bits <= '0;
        end else if (wr.we && tgt == TGT_KEY) begin
            for (int q = 0; q < KEPT_W; q++) begin
                if (int'(wr.addr) == (KEY_HI - q) / KEY_WORD_W) begin
                    key_bits[q] <= wr.data[KEY_WORD_W - 1 - ((KEY_HI - q) % KEY_WORD_W)];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
        end else if (wr.we && tgt == TGT_EN) begin
            enable <= wr.data[0];
        end
    end

    // Table base is aligned to the depth, so the low address bits are the entry.
    assign tbl_we   = wr.we && (tgt == TGT_TBL);
    assign tbl_idx  = wr.addr[IDX_W-1:0];
    assign tbl_data = wr.data[QUEUE_W-1:0];

    assert_enable_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr.we && wr.addr == CFG_ADDR_W'(EN_ADDR)) |=> (enable == $past(wr.data[0])))
        else $error("enable bit did not take the written value");

endmodule

// File: rtl/rss_indir_table.sv
module rss_indir_table
    import rss_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [QUEUE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [QUEUE_W-1:0] rd_data
);

    logic [QUEUE_W-1:0] entry [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_DEPTH; i++) begin
                entry[i] <= '0;
            end
        end else if (wr_en) begin
            entry[wr_idx] <= wr_data;
        end
    end

    assign rd_data = entry[rd_idx];

    assert_table_write_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (entry[$past(wr_idx)] == $past(wr_data)))
        else $error("table entry did not take the written value");

endmodule

// File: rtl/rss_toeplitz_index.sv
module rss_toeplitz_index
    import rss_pkg::*;
(
    input  logic [TUPLE_W-1:0] tuple,
    input  kept_key_t          key_bits,
    output logic [IDX_W-1:0]   idx
);

    logic [TUPLE_WORDS-1:0][IDX_W-1:0] part;

    for (genvar w = 0; w < TUPLE_WORDS; w++) begin : g_word
        assign part[w] = word_fold(tuple[w*TUPLE_WORD_W +: TUPLE_WORD_W],
                                   key_bits[w*TUPLE_WORD_W +: WORD_SPAN_W]);
    end

    always_comb begin
        idx = '0;
        for (int w = 0; w < TUPLE_WORDS; w++) begin
            idx = idx ^ part[w];
        end
    end

    always_comb begin
        if (tuple == '0) begin
            assert_zero_hash_R2: assert (idx == '0)
                else $error("zero tuple produced nonzero index");
        end
    end

endmodule

// File: rtl/rss_queue_select.sv
module rss_queue_select
    import rss_pkg::*;
#(
    parameter int DATA_W = 512,
    parameter int META_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    input  logic                  s_tvalid,
    output logic                  s_tready,
    input  logic [DATA_W-1:0]     s_tdata,
    input  logic [DATA_W/8-1:0]   s_tkeep,
    input  logic                  s_tlast,
    input  logic [TUPLE_W-1:0]    s_tuple,
    input  logic [META_W-1:0]     s_meta,
    output logic                  m_tvalid,
    input  logic                  m_tready,
    output logic [DATA_W-1:0]     m_tdata,
    output logic [DATA_W/8-1:0]   m_tkeep,
    output logic                  m_tlast,
    output logic [META_W-1:0]     m_meta
);

    localparam int KEEP_W = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [KEEP_W-1:0] keep;
        logic              last;
        logic [META_W-1:0] meta;
    } beat_t;

    cfg_wr_t            cfg_wr;
    kept_key_t          key_bits;
    logic               rss_en;
    logic               tbl_we;
    logic [IDX_W-1:0]   tbl_widx;
    logic [QUEUE_W-1:0] tbl_wdata;
    logic [QUEUE_W-1:0] queue_sel;
    logic [IDX_W-1:0]   idx_now;

    beat_t            in_beat, s1_beat, s2_beat, s2_next;
    logic             s1_v, s2_v;
    logic [IDX_W-1:0] s1_idx;
    logic             adv1, adv2;

    assign cfg_wr  = '{we: cfg_we, addr: cfg_addr, data: cfg_wdata};
    assign in_beat = '{data: s_tdata, keep: s_tkeep, last: s_tlast, meta: s_meta};

    rss_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .key_bits (key_bits),
        .enable   (rss_en),
        .tbl_we   (tbl_we),
        .tbl_idx  (tbl_widx),
        .tbl_data (tbl_wdata)
    );

    rss_toeplitz_index u_hash (
        .tuple    (s_tuple),
        .key_bits (key_bits),
        .idx      (idx_now)
    );

    rss_indir_table u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_widx),
        .wr_data (tbl_wdata),
        .rd_idx  (s1_idx),
        .rd_data (queue_sel)
    );

    // Stage advance: output moves when drained or empty, stage 1 also fills into a bubble.
    assign adv2     = m_tready || !s2_v;
    assign adv1     = adv2 || !s1_v;
    assign s_tready = adv1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
        end else begin
            if (adv1) s1_v <= s_tvalid;
            if (adv2) s2_v <= s1_v;
        end
    end

    always_ff @(posedge clk) begin
        if (adv1 && s_tvalid) begin
            s1_beat <= in_beat;
            s1_idx  <= idx_now;
        end
    end

    always_comb begin
        s2_next = s1_beat;
        if (rss_en && s1_beat.last) begin
            s2_next.meta[QUEUE_W-1:0] = queue_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (adv2 && s1_v) begin
            s2_beat <= s2_next;
        end
    end

    assign m_tvalid = s2_v;
    assign m_tdata  = s2_beat.data;
    assign m_tkeep  = s2_beat.keep;
    assign m_tlast  = s2_beat.last;
    assign m_meta   = s2_beat.meta;

    assert_ready_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
        !m_tvalid |-> s_tready)
        else $error("input stalled while output empty");

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                                     && $stable(m_tlast) && $stable(m_meta)))
        else $error("output changed during stall");

    assert_fixed_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready) ##1 (m_tready || !m_tvalid) |=> m_tvalid)
        else $error("accepted beat missing after fixed delay");

endmodule

// File: tb/sim_rss_queue_select.sv
module sim_rss_queue_select;
    import rss_pkg::*;

    localparam int DW = 512;
    localparam int MW = 32;
    localparam int EQ = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [7:0]    cfg_addr;
    logic [15:0]   cfg_wdata;
    logic          s_tvalid, s_tready, s_tlast;
    logic [DW-1:0] s_tdata;
    logic [DW/8-1:0] s_tkeep;
    logic [95:0]   s_tuple;
    logic [MW-1:0] s_meta;
    logic          m_tvalid, m_tready, m_tlast;
    logic [DW-1:0] m_tdata;
    logic [DW/8-1:0] m_tkeep;
    logic [MW-1:0] m_meta;

    always #10 clk = ~clk;

    rss_queue_select #(.DATA_W(DW), .META_W(MW)) u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .s_tkeep(s_tkeep), .s_tlast(s_tlast), .s_tuple(s_tuple), .s_meta(s_meta),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_meta(m_meta)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model of the programmed state
    logic [319:0] mk_key;
    logic [7:0]   mk_tbl [64];
    logic         mk_en;

    // Expected output beats
    logic [DW-1:0] e_data [EQ];
    logic          e_last [EQ];
    logic [MW-1:0] e_meta [EQ];
    string         e_tag  [EQ];
    int e_wr = 0;
    int e_rd = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_hash(input logic [95:0] t);
        logic [127:0] w;
        logic [31:0]  h;
        w = mk_key[319:192];
        h = '0;
        for (int i = 0; i < 96; i++) begin
            if (t[95-i]) h = h ^ w[127:96];
            w = w << 1;
        end
        return h;
    endfunction

    function automatic logic [MW-1:0] exp_meta(input logic [95:0] t, input logic [MW-1:0] m,
                                               input bit last);
        logic [31:0] h;
        if (!(mk_en && last)) return m;
        h = ref_hash(t);
        return {m[MW-1:8], mk_tbl[h[5:0]]};
    endfunction

    // Output monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst && m_tvalid && m_tready) begin
            if (e_rd >= e_wr) begin
                check(1'b0, "R8", "unexpected output beat", m_tdata[63:0], 64'h0);
            end else begin
                check(m_tdata == e_data[e_rd % EQ], "R8", "data passthrough",
                      m_tdata[63:0], e_data[e_rd % EQ][63:0]);
                check(m_tlast == e_last[e_rd % EQ] && m_tkeep == '1, "R8", "last/keep passthrough",
                      64'(m_tlast), 64'(e_last[e_rd % EQ]));
                check(m_meta == e_meta[e_rd % EQ], e_tag[e_rd % EQ], "metadata/queue",
                      64'(m_meta), 64'(e_meta[e_rd % EQ]));
            end
            e_rd++;
        end
    end

    task automatic cfg_write(input int a, input logic [15:0] d);
        cfg_we    = 1'b1;
        cfg_addr  = 8'(a);
        cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (a < 20) mk_key[319 - 16*a -: 16] = d;
        else if (a >= 64 && a < 128) mk_tbl[a-64] = d[7:0];
        else if (a == 128) mk_en = d[0];
    endtask

    task automatic send_packet(input int nb, input logic [95:0] t, input logic [MW-1:0] m,
                               input logic [31:0] seed, input string tag);
        for (int b = 0; b < nb; b++) begin
            logic [DW-1:0] d;
            bit lst;
            d   = {16{seed + 32'(b)}};
            lst = (b == nb - 1);
            e_data[e_wr % EQ] = d;
            e_last[e_wr % EQ] = lst;
            e_meta[e_wr % EQ] = exp_meta(t, m, lst);
            e_tag[e_wr % EQ]  = tag;
            e_wr++;
            s_tvalid = 1'b1;
            s_tdata  = d;
            s_tkeep  = '1;
            s_tlast  = lst;
            s_tuple  = t;
            s_meta   = m;
            @(negedge clk);
            while (!s_tready) @(negedge clk);
            @(posedge clk); #1;
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 200; i++) begin
            if (e_rd == e_wr) break;
            @(negedge clk);
        end
        check(e_rd == e_wr, tag, "all expected beats delivered", 64'(e_rd), 64'(e_wr));
        @(posedge clk); #1;
    endtask

    // Scenarios
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(m_tvalid == 1'b0, "R10", "output valid after reset", 64'(m_tvalid), 64'h0);
        check(s_tready == 1'b1, "R6", "ready after reset", 64'(s_tready), 64'h1);
        @(posedge clk); #1;
        // enable cleared by reset: metadata passes unmodified
        send_packet(1, 96'h0A000001_0A000002_1234_0050, 32'hCAFE_0042, 32'h1000, "R10");
        drain("R10");
    endtask

    task automatic t_program();
        for (int a = 0; a < 20; a++) cfg_write(a, 16'h6d5a ^ 16'(a * 16'h1357));
        for (int i = 0; i < 64; i++) cfg_write(64 + i, 16'(i * 3 + 7));
        cfg_write(128, 16'h0001);
    endtask

    task automatic t_hash_patterns();
        send_packet(1, 96'hC0A80001_C0A80002_0400_0050, 32'h1111_1100, 32'h2000, "R1");
        send_packet(1, 96'h42A3F101_0A0B0C0D_D431_01BB, 32'hABCD_EF00, 32'h2100, "R1");
        send_packet(1, 96'hFFFFFFFF_FFFFFFFF_FFFF_FFFF, 32'h5A5A_5AFF, 32'h2200, "R1");
        send_packet(1, 96'h00000000_00000000_0000_0001, 32'h0F0F_0F33, 32'h2300, "R3");
        send_packet(2, 96'h80000000_00000001_8001_0002, 32'h7654_3210, 32'h2400, "R3");
        drain("R1");
    endtask

    task automatic t_zero_tuple();
        cfg_write(64, 16'h00A5);
        send_packet(1, 96'h0, 32'h9999_9900, 32'h3000, "R2");
        drain("R2");
    endtask

    task automatic t_latency();
        send_packet(1, 96'h01020304_05060708_0909_0A0A, 32'h0000_0000, 32'h4000, "R8");
        @(negedge clk);
        check(m_tvalid == 1'b0, "R8", "no output one edge after accept", 64'(m_tvalid), 64'h0);
        @(negedge clk);
        check(m_tvalid == 1'b1, "R8", "output two edges after accept", 64'(m_tvalid), 64'h1);
        @(posedge clk); #1;
        drain("R8");
    endtask

    task automatic t_burst();
        int lows;
        lows = 0;
        fork
            begin
                send_packet(3, 96'h11111111_22222222_3333_4444, 32'hAAAA_0000, 32'h5000, "R6");
                send_packet(2, 96'h55555555_66666666_7777_8888, 32'hBBBB_0000, 32'h5100, "R6");
                send_packet(1, 96'h99999999_AAAAAAAA_BBBB_CCCC, 32'hCCCC_0000, 32'h5200, "R6");
            end
            begin
                repeat (7) begin
                    @(negedge clk);
                    if (!s_tready) lows++;
                end
            end
        join
        check(lows == 0, "R6", "ready drops with downstream ready high", 64'(lows), 64'h0);
        drain("R6");
    endtask

    task automatic t_stall();
        fork
            send_packet(4, 96'hDEADBEEF_01234567_89AB_CDEF, 32'h1357_9B00, 32'h6000, "R7");
            begin
                logic [DW-1:0] hd;
                logic [MW-1:0] hm;
                @(negedge clk);
                while (!m_tvalid) @(negedge clk);
                @(posedge clk); #1;
                m_tready = 1'b0;
                @(negedge clk);
                hd = m_tdata;
                hm = m_meta;
                repeat (4) begin
                    @(negedge clk);
                    check(m_tvalid && m_tdata == hd && m_meta == hm, "R7", "output held in stall",
                          m_tdata[63:0], hd[63:0]);
                end
                @(posedge clk); #1;
                m_tready = 1'b1;
            end
        join
        drain("R7");
    endtask

    task automatic t_enable_off();
        cfg_write(128, 16'h0000);
        send_packet(2, 96'hC0A80101_08080808_1F90_0035, 32'h1234_5678, 32'h7000, "R5");
        drain("R5");
        cfg_write(128, 16'h0001);
    endtask

    task automatic t_inflight_key();
        logic [95:0] t;
        t = 96'h7FFF8000_0A000001_1111_2222;
        send_packet(1, t, 32'h4242_4200, 32'h8000, "R9");
        cfg_write(2, mk_key[319-32 -: 16] ^ 16'hFFFF);
        send_packet(1, t, 32'h4343_4300, 32'h8100, "R9");
        drain("R9");
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        s_tvalid = 1'b0; s_tdata = '0; s_tkeep = '0; s_tlast = 1'b0;
        s_tuple = '0; s_meta = '0; m_tready = 1'b1;
        mk_key = '0; mk_en = 1'b0;
        for (int i = 0; i < 64; i++) mk_tbl[i] = 8'h00;
        t_reset();
        t_program();
        t_hash_patterns();
        t_zero_tuple();
        t_latency();
        t_burst();
        t_stall();
        t_enable_off();
        t_inflight_key();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule